// File: doc/BRIEF.md
# Low-Power PWM Timer

A single-channel pulse-width modulation timer. It runs from one clock through a power-of-two prescaler and is programmed through a small word-addressed register bus. An up-counter steps once per prescaled tick from zero to a reload value and then wraps. The raw waveform is active while the count is above a compare value. A polarity bit inverts the waveform at the pin.

The control register has two bits. An enable bit opens the reload and compare registers to writes, and a start bit, honoured only together with enable, sets the counter running. The configuration register holds the prescaler exponent and the polarity. It accepts writes only while the timer is disabled. A reload or compare write is accepted only while the timer is enabled. The new value lands one clock later, and at that point a sticky confirmation flag is set. Software clears these flags by writing ones to a separate clear register.

A typical driver writes the configuration, sets enable, writes reload and compare, polls both confirmation flags, clears them, and then sets enable and start together.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset, every register reads zero and `pwm_out` is low.
- R2: Control (address 0) holds enable in bit 0 and start in bit 1. The timer runs only while both are set. Start is stored as zero unless enable is written as one in the same write. Writing zero stops the timer. The register reads back as {start, enable}.
- R3: Configuration (address 1) holds the prescaler exponent N in bits [2:0] and the polarity in bit 3. A write to it while enable is set is ignored.
- R4: A write to reload (address 2) or compare (address 3) while enable is clear is ignored. The register keeps its value and no flag is set.
- R5: For an accepted write to reload or compare, the clock edge that samples the write is edge 0. The new value and its flag both appear at edge 1. The reload flag is status bit 0 and the compare flag is status bit 1 (status is address 4).
- R6: Writing to the clear register (address 5) clears each status flag whose bit is written as one. If a flag is set and cleared at the same edge, the set wins.
- R7: While running, the count advances once every 2^N clocks, from 0 up to the reload value, and then returns to 0. The waveform period is (reload+1)·2^N clocks.
- R8: While running, the raw waveform is active exactly while the count is greater than compare. This gives (reload−compare)·2^N active clocks per period when compare < reload.
- R9: `pwm_out` equals the raw waveform XOR the polarity bit. While the timer is not running, `pwm_out` equals the polarity bit, and the counter and prescaler are held at zero.
- R10: `rdata` is combinational. It shows the addressed register while `rd_en` is high, and it reads zero when `rd_en` is low or the address is 6 or 7. The clear register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock for bus and counter |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of `rd_en` |
| pwm_out | output | 1 | Waveform after polarity |

## Verification
Two events can meet on the same clock edge: a confirmation flag being set as a reload or compare value lands, and a clear-register write aimed at that same flag. The bench provokes this by issuing the clear write in the cycle directly after a compare write. It then expects the compare flag still to read one, and a second clear to bring it to zero. Stopping the timer and counter wrap can also coincide. A behavioural model, advanced every clock, compares `pwm_out` in every cycle, so an output that lags the stop by one cycle is caught.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RELOAD = 3'd2,
    A_CMP    = 3'd3,
    A_STAT   = 3'd4,
    A_CLR    = 3'd5
  } reg_addr_e;

  // index of each confirmed register in the shadow array and status word
  localparam int SH_RELOAD = 0;
  localparam int SH_CMP    = 1;
  localparam int N_SHADOW  = 2;
endpackage

// File: rtl/lpt_shadow_reg.sv
module lpt_shadow_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [DATA_W-1:0] value,
  output logic              ok
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pdat_q, pdat_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              ok_q, ok_d;

  always_comb begin
    pend_d = accept;
    pdat_d = pdat_q;
    if (accept) pdat_d = wdata;
    val_d = val_q;
    if (pend_q) val_d = pdat_q;
    ok_d = ok_q & ~clr;
    if (pend_q) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pdat_q <= '0;
      val_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pdat_q <= pdat_d;
      val_q  <= val_d;
      ok_q   <= ok_d;
    end
  end

  assign value = val_q;
  assign ok    = ok_q;

  AST_OK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(accept, 2)); // R5
  AST_VAL_ONLY_ON_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(val_q) |-> $past(accept, 2)); // R4
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pend_q) |=> !ok_q); // R6
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept) && clr) |=> ok_q); // R6
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic [PSC_W-1:0]  psc_sel,
  output logic              pol,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] compare
);
  logic             en_q, en_d;
  logic             run_q, run_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             pol_q, pol_d;

  logic                          wr_ctrl, wr_cfg, wr_clr;
  logic [N_SHADOW-1:0]           sh_acc, sh_clr, sh_ok;
  logic [N_SHADOW-1:0][DATA_W-1:0] sh_val;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cfg  = wr_en && (addr == A_CFG) && !en_q;
  assign wr_clr  = wr_en && (addr == A_CLR);

  assign sh_acc[SH_RELOAD] = wr_en && (addr == A_RELOAD) && en_q;
  assign sh_acc[SH_CMP]    = wr_en && (addr == A_CMP)    && en_q;

  always_comb begin
    en_d  = en_q;
    run_d = run_q;
    psc_d = psc_q;
    pol_d = pol_q;
    if (wr_ctrl) begin
      en_d  = wdata[0];
      run_d = wdata[0] & wdata[1];
    end
    if (wr_cfg) begin
      psc_d = wdata[PSC_W-1:0];
      pol_d = wdata[PSC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      psc_q <= '0;
      pol_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      run_q <= run_d;
      psc_q <= psc_d;
      pol_q <= pol_d;
    end
  end

  for (genvar i = 0; i < N_SHADOW; i++) begin : g_shadow
    assign sh_clr[i] = wr_clr && wdata[i];
    lpt_shadow_reg #(.DATA_W(DATA_W)) u_sh (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (sh_acc[i]),
      .wdata  (wdata),
      .clr    (sh_clr[i]),
      .value  (sh_val[i]),
      .ok     (sh_ok[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:   rdata[1:0] = {run_q, en_q};
        A_CFG:    rdata[PSC_W:0] = {pol_q, psc_q};
        A_RELOAD: rdata = sh_val[SH_RELOAD];
        A_CMP:    rdata = sh_val[SH_CMP];
        A_STAT:   rdata[N_SHADOW-1:0] = sh_ok;
        default:  rdata = '0;
      endcase
    end
  end

  assign run     = run_q;
  assign psc_sel = psc_q;
  assign pol     = pol_q;
  assign reload  = sh_val[SH_RELOAD];
  assign compare = sh_val[SH_CMP];

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pol_q, psc_q}) |-> $past(wr_en && (addr == A_CFG) && !en_q)); // R3
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q); // R2
  AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q) && !$past(sh_ok[SH_RELOAD])) |-> !sh_ok[SH_RELOAD]); // R4
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, lim;

  assign lim  = ~({DIV_W{1'b1}} << sel);
  assign tick = run && (div_q == lim);

  always_comb begin
    div_d = div_q;
    if (!run)      div_d = '0;
    else if (tick) div_d = '0;
    else           div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_q <= lim)); // R7
  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0)); // R9
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [DATA_W-1:0] reload,
  input  logic [DATA_W-1:0] compare,
  input  logic              pol,
  output logic              pwm
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              raw;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                   cnt_d = '0;
    else if (tick) begin
      if (cnt_q >= reload)      cnt_d = '0;
      else                      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign raw = run && (cnt_q > compare);
  assign pwm = raw ^ pol;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt_q != '0) |->
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm == pol)); // R9
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer
  import lpt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  logic              run, pol, tick;
  logic [PSC_W-1:0]  psc_sel;
  logic [DATA_W-1:0] reload, compare;

  lpt_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .run     (run),
    .psc_sel (psc_sel),
    .pol     (pol),
    .reload  (reload),
    .compare (compare)
  );

  lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (psc_sel),
    .tick  (tick)
  );

  lpt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .reload  (reload),
    .compare (compare),
    .pol     (pol),
    .pwm     (pwm_out)
  );
endmodule

// File: tb/lp_pwm_timer_bench.sv
`timescale 1ns/1ps
module lp_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit live  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  lp_pwm_timer u_lp_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int m_en, m_run, m_n, m_pol, m_arr, m_cmp, m_okr, m_okc;
  int m_pr, m_pc, m_pdr, m_pdc, m_div, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_n = 0; m_pol = 0; m_arr = 0; m_cmp = 0;
      m_okr = 0; m_okc = 0; m_pr = 0; m_pc = 0; m_pdr = 0; m_pdc = 0;
      m_div = 0; m_cnt = 0;
    end else begin
      int o_en, o_run, o_n, o_arr, o_pr, o_pc;
      o_en = m_en; o_run = m_run; o_n = m_n; o_arr = m_arr;
      o_pr = m_pr; o_pc = m_pc;
      // counter from old state
      if (o_run == 0) begin m_div = 0; m_cnt = 0; end
      else if (m_div == (1 << o_n) - 1) begin
        m_div = 0;
        m_cnt = (m_cnt >= o_arr) ? 0 : m_cnt + 1;
      end else m_div = m_div + 1;
      // clears, then landing sets
      if (wr_en && addr == 5) begin
        if (wdata[0]) m_okr = 0;
        if (wdata[1]) m_okc = 0;
      end
      if (o_pr) begin m_arr = m_pdr; m_okr = 1; end
      if (o_pc) begin m_cmp = m_pdc; m_okc = 1; end
      m_pr = (wr_en && addr == 2 && o_en) ? 1 : 0;
      m_pc = (wr_en && addr == 3 && o_en) ? 1 : 0;
      if (m_pr) m_pdr = wdata;
      if (m_pc) m_pdc = wdata;
      if (wr_en && addr == 0) begin
        m_en = wdata[0]; m_run = wdata[0] & wdata[1];
      end
      if (wr_en && addr == 1 && o_en == 0) begin
        m_n = wdata[2:0]; m_pol = wdata[3];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R8 / R9: output compared against the model every cycle
  always @(negedge clk) begin
    if (live && rst_n) begin
      int e;
      e = ((m_run != 0 && m_cnt > m_cmp) ? 1 : 0) ^ m_pol;
      chk(pwm_out == e, "R8 per-cycle pwm_out", pwm_out, e);
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = a[2:0]; wdata = d[15:0];
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, input int exp, input string tag, input bit en = 1'b1);
    rd_en = en; addr = a[2:0];
    #1;
    chk(rdata == exp[15:0], tag, rdata, exp);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input bit act, input int e_per, input int e_on, input string tag);
    int guard = 0;
    int per = 0;
    int on = 0;
    while (pwm_out == act && guard < 2000) begin @(negedge clk); guard++; end
    while (pwm_out != act && guard < 2000) begin @(negedge clk); guard++; end
    forever begin
      bit cur;
      cur = pwm_out;
      per++;
      if (cur == act) on++;
      @(negedge clk);
      if ((pwm_out == act && cur != act) || per > 2000) break;
    end
    chk(per == e_per, {tag, " period"}, per, e_per);
    chk(on == e_on, {tag, " active time"}, on, e_on);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(a, 0, "R1 reset register");
    chk(pwm_out == 1'b0, "R1 reset pwm_out", pwm_out, 0);

    // R4 reload/compare locked while disabled
    wr(2, 9);
    wr(3, 4);
    idle(2);
    rd(2, 0, "R4 reload ignored when disabled");
    rd(3, 0, "R4 compare ignored when disabled");
    rd(4, 0, "R4 no flag when disabled");

    // R3 config write while disabled, then locked while enabled
    wr(1, 1);
    rd(1, 1, "R3 config accepted");
    wr(0, 1);
    rd(0, 1, "R2 enable readback");
    wr(1, 5);
    rd(1, 1, "R3 config locked while enabled");

    // R5 reload write latency
    wr(2, 9);
    rd(4, 0, "R5 flag not yet after one edge");
    rd(4, 1, "R5 reload flag after second edge");
    rd(2, 9, "R5 reload value landed");
    wr(5, 1);
    rd(4, 0, "R6 reload flag cleared");

    // R6 set and clear on the same edge: set wins
    wr(3, 4);
    wr(5, 2);
    rd(4, 2, "R6 set beats same-edge clear");
    rd(3, 4, "R5 compare value landed");
    wr(5, 3);
    rd(4, 0, "R6 second clear");

    // R7 R8 run with N=1, reload 9, compare 5
    wr(3, 5);
    idle(2);
    wr(0, 3);
    rd(0, 3, "R2 enable and start readback");
    measure(1'b1, 20, 8, "R7 R8 N=1 reload=9 compare=5");

    // R9 stop, invert polarity, restart
    wr(0, 0);
    chk(pwm_out == 1'b0, "R9 stopped output at polarity 0", pwm_out, 0);
    wr(1, 8);
    rd(1, 8, "R3 polarity set");
    chk(pwm_out == 1'b1, "R9 stopped output at polarity 1", pwm_out, 1);
    wr(0, 3);
    measure(1'b0, 10, 4, "R9 inverted N=0");

    // R2 enable without start holds the output inactive
    wr(0, 1);
    idle(5);
    chk(pwm_out == 1'b1, "R2 enabled but not started", pwm_out, 1);
    rd(0, 1, "R2 start dropped");
    wr(0, 2);
    rd(0, 0, "R2 start without enable stored as zero");

    // R7 R8 new values while enabled then running
    wr(0, 1);
    wr(2, 3);
    wr(3, 1);
    idle(2);
    wr(0, 3);
    measure(1'b0, 4, 2, "R7 R8 reload=3 compare=1");
    wr(2, 7);
    idle(3);
    measure(1'b0, 8, 6, "R7 reload changed while running");

    // R10 read strobe and unmapped addresses
    rd(6, 0, "R10 unmapped address 6");
    rd(7, 0, "R10 unmapped address 7");
    rd(5, 0, "R10 clear register reads zero");
    rd(2, 0, "R10 rdata zero without rd_en", 1'b0);
    rd(2, 7, "R10 reload readback");

    done = 1;
    summary();
    $finish;
  end
endmodule